// File: doc/BRIEF.md
# Isochronous Bridge Channel Status Register

This block holds the 16-bit read-only status word for one channel of an isochronous packet bridge. It keeps the transmit and receive busy states, which follow the start and stop command strobes. It raises a flag when the first packet arrives after receive is started. It compares the 2-bit EMI field and the 1-bit odd/even field of each received header with those of the packet accepted before it.

Eight error pulses from the packet checker are latched into sticky bits. The sticky bits clear when the host reads the word. If a new event arrives in the same cycle as the read, the event is kept. The FIFO full and empty bits are not latched; they show the live FIFO levels.

The host reads the word combinationally from `statusWord`. It pulses `regRead` in the cycle the value is taken, and the sticky bits clear at the end of that cycle.

Top module: `iso_chan_status`

## Requirements
- R1: While reset is held and afterwards until the first event, `statusWord` reads 0x0008 when `fifoEmpty`=1 and `fifoFull`=0.
- R2: Bit 15 (transmit busy) becomes 1 in the cycle after `txStartCmd`. It becomes 0 in the cycle after `txEndCmd`. When both strobes come together, the end command wins.
- R3: Bit 14 (receive busy) behaves the same way with `rxStartCmd` and `rxEndCmd`, and the end command also wins there.
- R4: Bit 13 sets in the cycle after the first `hdrValid` that is accepted after a receive start. Later packets before the next start do not set it again.
- R5: Bit 12 sets after an accepted packet whose `hdrEmi` differs from the EMI of the previously accepted packet. The first packet accepted after a start never sets it.
- R6: Bit 11 does the same for `hdrOddEven`, with the same first-packet exemption.
- R7: A `hdrValid` pulse is accepted only while bit 14 is 1. A pulse while receive is stopped sets no flag and does not update the stored reference header. A `rxStartCmd` clears the reference.
- R8: The error pulses latch into these bits: `errEvt[0]`→bit 0, [1]→bit 1, [2]→bit 2, [3]→bit 5, [4]→bit 6, [5]→bit 7, [6]→bit 8, [7]→bit 10. Each bit stays 1 until a read.
- R9: A cycle with `regRead`=1 clears bits 13..10, 8..5 and 2..0 at the end of that cycle. An event in that same cycle leaves its bit at 1.
- R10: Bit 4 equals `fifoFull` and bit 3 equals `fifoEmpty` in the same cycle, with no latching. Bit 9 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txStartCmd | input | 1 | Transmit start command strobe |
| txEndCmd | input | 1 | Transmit end command strobe |
| rxStartCmd | input | 1 | Receive start command strobe |
| rxEndCmd | input | 1 | Receive end command strobe |
| hdrValid | input | 1 | Received header valid pulse |
| hdrEmi | input | 2 | EMI field of the received header |
| hdrOddEven | input | 1 | Odd/even field of the received header |
| errEvt | input | 8 | Error event pulses, mapping in R8 |
| fifoFull | input | 1 | Live FIFO full level |
| fifoEmpty | input | 1 | Live FIFO empty level |
| regRead | input | 1 | Status word read strobe |
| statusWord | output | 16 | Status word |

## Verification
The checker runs on every cycle and covers these properties:
- the busy bits respond to the start and end strobes;
- the FIFO bits pass straight through;
- a sticky bit holds until it is read, and the read clears it;
- an event in the same cycle as a read still wins;
- a stopped receiver does not raise the first-packet flag.

Only the bench's packet sequences can show the header-dependent results. These include whether a change flag rises against the previously accepted header. They also include the reference being dropped by a restart, and packets ignored while stopped leaving the reference unchanged.

// File: rtl/iso_stat_pkg.sv
package iso_stat_pkg;
  localparam int WORD_W   = 16;
  localparam int EMI_W    = 2;
  localparam int OE_W     = 1;
  localparam int ERR_N    = 8;
  localparam int N_STICKY = ERR_N + 3;

  localparam int POS_TX    = 15;
  localparam int POS_RX    = 14;
  localparam int POS_FULL  = 4;
  localparam int POS_EMPTY = 3;

  // Sticky index -> word bit: errors 0..7, then first packet, EMI change, odd/even change
  localparam int STICKY_POS [N_STICKY] = '{0, 1, 2, 5, 6, 7, 8, 10, 13, 12, 11};

  typedef struct packed {
    logic pktAccept;
    logic firstPkt;
    logic refClear;
    logic readClr;
  } ctlStrobe_t;
endpackage

// File: rtl/iso_stat_ctrl.sv
module iso_stat_ctrl
  import iso_stat_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       txStartCmd,
  input  logic       txEndCmd,
  input  logic       rxStartCmd,
  input  logic       rxEndCmd,
  input  logic       hdrValid,
  input  logic       regRead,
  output logic       txBusy,
  output logic       rxBusy,
  output ctlStrobe_t strb
);
  logic pendFirst;

  always_comb begin
    strb.pktAccept = hdrValid & rxBusy;
    strb.firstPkt  = hdrValid & rxBusy & pendFirst;
    strb.refClear  = rxStartCmd;
    strb.readClr   = regRead;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBusy    <= 1'b0;
      rxBusy    <= 1'b0;
      pendFirst <= 1'b0;
    end else begin
      if (txEndCmd)        txBusy <= 1'b0;
      else if (txStartCmd) txBusy <= 1'b1;
      if (rxEndCmd)        rxBusy <= 1'b0;
      else if (rxStartCmd) rxBusy <= 1'b1;
      if (rxStartCmd)          pendFirst <= 1'b1;
      else if (strb.pktAccept) pendFirst <= 1'b0;
    end
  end
endmodule

// File: rtl/iso_stat_dp.sv
module iso_stat_dp
  import iso_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [EMI_W-1:0]  hdrEmi,
  input  logic [OE_W-1:0]   hdrOddEven,
  input  logic [ERR_N-1:0]  errEvt,
  input  logic              fifoFull,
  input  logic              fifoEmpty,
  input  logic              txBusy,
  input  logic              rxBusy,
  output logic [WORD_W-1:0] statusWord
);
  logic                refValid;
  logic [EMI_W-1:0]    refEmi;
  logic [OE_W-1:0]     refOe;
  logic                emiDiff;
  logic                oeDiff;
  logic [N_STICKY-1:0] stickySet;
  logic [N_STICKY-1:0] stickyQ;

  assign emiDiff   = strb.pktAccept & refValid & (hdrEmi != refEmi);
  assign oeDiff    = strb.pktAccept & refValid & (hdrOddEven != refOe);
  assign stickySet = {oeDiff, emiDiff, strb.firstPkt, errEvt};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refValid <= 1'b0;
      refEmi   <= '0;
      refOe    <= '0;
    end else begin
      if (strb.pktAccept) begin
        refEmi <= hdrEmi;
        refOe  <= hdrOddEven;
      end
      if (strb.refClear)       refValid <= 1'b0;
      else if (strb.pktAccept) refValid <= 1'b1;
    end
  end

  generate
    for (genvar g = 0; g < N_STICKY; g++) begin : gSticky
      always_ff @(posedge clk) begin
        if (!rstN)             stickyQ[g] <= 1'b0;
        else if (stickySet[g]) stickyQ[g] <= 1'b1;
        else if (strb.readClr) stickyQ[g] <= 1'b0;
      end
    end
  endgenerate

  always_comb begin
    statusWord            = '0;
    statusWord[POS_TX]    = txBusy;
    statusWord[POS_RX]    = rxBusy;
    statusWord[POS_FULL]  = fifoFull;
    statusWord[POS_EMPTY] = fifoEmpty;
    for (int i = 0; i < N_STICKY; i++) statusWord[STICKY_POS[i]] = stickyQ[i];
  end
endmodule

// File: rtl/iso_chan_status.sv
module iso_chan_status
  import iso_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              txStartCmd,
  input  logic              txEndCmd,
  input  logic              rxStartCmd,
  input  logic              rxEndCmd,
  input  logic              hdrValid,
  input  logic [EMI_W-1:0]  hdrEmi,
  input  logic [OE_W-1:0]   hdrOddEven,
  input  logic [ERR_N-1:0]  errEvt,
  input  logic              fifoFull,
  input  logic              fifoEmpty,
  input  logic              regRead,
  output logic [WORD_W-1:0] statusWord
);
  ctlStrobe_t strb;
  logic       txBusy;
  logic       rxBusy;

  iso_stat_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .txStartCmd(txStartCmd), .txEndCmd(txEndCmd),
    .rxStartCmd(rxStartCmd), .rxEndCmd(rxEndCmd),
    .hdrValid(hdrValid), .regRead(regRead),
    .txBusy(txBusy), .rxBusy(rxBusy), .strb(strb)
  );

  iso_stat_dp uDp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .hdrEmi(hdrEmi), .hdrOddEven(hdrOddEven), .errEvt(errEvt),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
    .txBusy(txBusy), .rxBusy(rxBusy), .statusWord(statusWord)
  );
endmodule

// File: rtl/iso_chan_status_chk.sv
module iso_chan_status_chk
  import iso_stat_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              txStartCmd,
  input logic              txEndCmd,
  input logic              rxStartCmd,
  input logic              rxEndCmd,
  input logic              hdrValid,
  input logic [ERR_N-1:0]  errEvt,
  input logic              fifoFull,
  input logic              fifoEmpty,
  input logic              regRead,
  input logic [WORD_W-1:0] statusWord
);
  AST_TX_START: assert property (@(posedge clk) disable iff (!rstN)
    txStartCmd && !txEndCmd |=> statusWord[15]); // R2
  AST_TX_END: assert property (@(posedge clk) disable iff (!rstN)
    txEndCmd |=> !statusWord[15]); // R2
  AST_RX_START: assert property (@(posedge clk) disable iff (!rstN)
    rxStartCmd && !rxEndCmd |=> statusWord[14]); // R3
  AST_RX_END: assert property (@(posedge clk) disable iff (!rstN)
    rxEndCmd |=> !statusWord[14]); // R3
  AST_STOPPED_NO_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    hdrValid && !statusWord[14] && !statusWord[13] |=> !statusWord[13]); // R7
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !regRead && statusWord[0] |=> statusWord[0]); // R8
  AST_ERR_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    errEvt[7] |=> statusWord[10]); // R8
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    regRead && !errEvt[0] |=> !statusWord[0]); // R9
  AST_SET_BEATS_READ: assert property (@(posedge clk) disable iff (!rstN)
    regRead && errEvt[1] |=> statusWord[1]); // R9
  AST_FIFO_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[4] == fifoFull && statusWord[3] == fifoEmpty); // R10
endmodule

bind iso_chan_status iso_chan_status_chk uChk (
  .clk(clk), .rstN(rstN),
  .txStartCmd(txStartCmd), .txEndCmd(txEndCmd),
  .rxStartCmd(rxStartCmd), .rxEndCmd(rxEndCmd),
  .hdrValid(hdrValid), .errEvt(errEvt),
  .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
  .regRead(regRead), .statusWord(statusWord)
);

// File: tb/iso_chan_status_test.sv
`timescale 1ns/1ps
module iso_chan_status_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        txStartCmd = 0, txEndCmd = 0, rxStartCmd = 0, rxEndCmd = 0;
  logic        hdrValid = 0;
  logic [1:0]  hdrEmi = 0;
  logic        hdrOddEven = 0;
  logic [7:0]  errEvt = 0;
  logic        fifoFull = 0, fifoEmpty = 1, regRead = 0;
  logic [15:0] statusWord;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  // behavioural reference state
  bit mTx, mRx, mPend, mRefV;
  int mRefEmi, mRefOe;
  bit mErr[8];
  bit mFirst, mEmiChg, mOeChg;

  iso_chan_status uut (.*);

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      mismatched++;
      $display("FAIL: watchdog expired (all requirements) actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  function automatic string reqOf(int b);
    case (b)
      15: return "R2";
      14: return "R3";
      13: return "R4";
      12: return "R5";
      11: return "R6";
      9, 4, 3: return "R10";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [15:0] expWord();
    logic [15:0] w = 16'h0;
    w[15] = mTx; w[14] = mRx; w[13] = mFirst; w[12] = mEmiChg; w[11] = mOeChg;
    w[10] = mErr[7]; w[8] = mErr[6]; w[7] = mErr[5]; w[6] = mErr[4]; w[5] = mErr[3];
    w[2] = mErr[2]; w[1] = mErr[1]; w[0] = mErr[0];
    w[4] = fifoFull; w[3] = fifoEmpty;
    return w;
  endfunction

  task automatic compareNow(string tag);
    logic [15:0] e = expWord();
    compared++;
    if (statusWord !== e) begin
      mismatched++;
      for (int b = 0; b < 16; b++)
        if (statusWord[b] !== e[b])
          $display("FAIL: %s %s bit %0d actual=%h expected=%h", tag, reqOf(b), b, statusWord, e);
    end
  endtask

  task automatic modelEdge();
    bit acc = hdrValid && mRx;
    if (regRead) begin
      mFirst = 0; mEmiChg = 0; mOeChg = 0;
      for (int i = 0; i < 8; i++) mErr[i] = 0;
    end
    for (int i = 0; i < 8; i++) if (errEvt[i]) mErr[i] = 1;
    if (acc && mPend) mFirst = 1;
    if (acc && mRefV && int'(hdrEmi) != mRefEmi) mEmiChg = 1;
    if (acc && mRefV && int'(hdrOddEven) != mRefOe) mOeChg = 1;
    if (acc) begin mRefEmi = hdrEmi; mRefOe = hdrOddEven; mRefV = 1; mPend = 0; end
    if (rxStartCmd) begin mRefV = 0; mPend = 1; end
    if (txEndCmd) mTx = 0; else if (txStartCmd) mTx = 1;
    if (rxEndCmd) mRx = 0; else if (rxStartCmd) mRx = 1;
  endtask

  // called at a negedge with stimulus already driven
  task automatic step(string tag);
    #1 compareNow(tag);
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    txStartCmd = 0; txEndCmd = 0; rxStartCmd = 0; rxEndCmd = 0;
    hdrValid = 0; errEvt = 0; regRead = 0;
  endtask

  task automatic pkt(int emi, int oe, string tag);
    hdrValid = 1; hdrEmi = emi[1:0]; hdrOddEven = oe[0];
    step(tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    compared++; // R1 check during reset
    if (statusWord !== 16'h0008) begin
      mismatched++;
      $display("FAIL: R1 reset word actual=%h expected=0008", statusWord);
    end
    @(negedge clk);
    rstN = 1'b1;
    idle(2, "R1 idle after reset");

    // R2: transmit busy
    txStartCmd = 1; step("R2 start");
    idle(2, "R2 busy");
    txEndCmd = 1; step("R2 end");
    txStartCmd = 1; step("R2 restart");
    txStartCmd = 1; txEndCmd = 1; step("R2 both, end wins");
    idle(1, "R2 after both");

    // R3/R4/R5/R6
    rxStartCmd = 1; step("R3 start");
    pkt(1, 0, "R4 first packet");
    pkt(1, 1, "R6 odd/even change");
    regRead = 1; step("R9 read");
    pkt(2, 1, "R5 EMI change");
    pkt(2, 1, "R4 no second first flag");
    regRead = 1; step("R9 read");
    hdrValid = 1; hdrEmi = 3; hdrOddEven = 0; regRead = 1; step("R9 set beats read");
    idle(1, "R9 hold");
    regRead = 1; step("R9 read");

    // R7: stopped receiver ignores packets and keeps its reference
    rxEndCmd = 1; step("R3 end");
    pkt(0, 1, "R7 ignored packet");
    idle(1, "R7 no flags");
    rxStartCmd = 1; step("R7 restart");
    pkt(0, 1, "R5 first after restart, no change");
    pkt(0, 1, "R6 same header");
    regRead = 1; step("R9 read");
    rxStartCmd = 1; rxEndCmd = 1; step("R3 both, end wins");
    pkt(3, 0, "R7 ignored");

    // R8: each error pulse
    for (int i = 0; i < 8; i++) begin errEvt = 8'(1 << i); step("R8 error pulse"); end
    idle(2, "R8 hold");
    regRead = 1; errEvt = 8'h02; step("R9 read with event");
    idle(1, "R9 after read");
    regRead = 1; step("R9 final read");

    // R10: live FIFO levels
    fifoEmpty = 0; step("R10 not empty");
    fifoFull = 1; step("R10 full");
    fifoFull = 0; fifoEmpty = 1; step("R10 empty");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      txStartCmd = ($urandom_range(0, 19) == 0);
      txEndCmd   = ($urandom_range(0, 29) == 0);
      rxStartCmd = ($urandom_range(0, 24) == 0);
      rxEndCmd   = ($urandom_range(0, 39) == 0);
      hdrValid   = ($urandom_range(0, 2) == 0);
      hdrEmi     = 2'($urandom_range(0, 3));
      hdrOddEven = ($urandom_range(0, 3) == 0);
      errEvt     = ($urandom_range(0, 5) == 0) ? 8'($urandom_range(0, 255)) : 8'h00;
      regRead    = ($urandom_range(0, 6) == 0);
      fifoFull   = ($urandom_range(0, 7) == 0);
      fifoEmpty  = ($urandom_range(0, 2) == 0);
      step("R2 R3 R4 R5 R6 R7 R8 R9 R10 random");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule